// File: doc/BRIEF.md
# Banked Memory Self-Test Engine

This block is a power-up self-test for a buffer memory that can only be reached one bank at a time through a fixed-size window. After a start pulse it makes four passes over every bank, in bank order. The first pass fills each word with a bank-dependent seed plus the word index. The second pass reads every word back and compares it. The third pass clears every word to zero. The fourth pass reads every word and expects zero. Before it touches the window of a bank in any pass, the engine issues a bank-load strobe carrying that bank's number.

Reads have one cycle of latency. The engine issues a read, waits one cycle, then compares the returned word. The first mismatch stops the test at once, and the engine records the bank and the word index of that failure. The result stays on the outputs until the next start. The number of banks, the words per bank, the data width and the seed step are parameters.

All pins are plain control and data pins. The memory side has no back-pressure: every access the engine issues completes in the cycle it is issued, and read data is due exactly one cycle later.

Top module: `banked_mem_bist`

## Requirements
- R1: A one-cycle `start` while the engine is idle or finished begins a test. A `start` while `busy` is high is ignored. A clean run keeps `busy` high for exactly 4*BANKS + 6*BANKS*WORDS cycles.
- R2: In every pass, banks are visited in the order 0 to BANKS-1. Each visit begins with a one-cycle `bank_load` carrying `bank_idx`, and no window access happens before the first load of a run. A clean run makes exactly 4*BANKS loads.
- R3: The fill pass writes word w of bank b with (b*SEED_STEP + w) mod 2^DATA_W, in ascending word order. SEED_STEP defaults to 0x1000.
- R4: The verify pass compares the data returned one cycle after each `rd_en` with the fill value of that word. It stops at the first mismatch.
- R5: The clear pass writes zero to every word of every bank. A clean run makes exactly 2*BANKS*WORDS writes.
- R6: The zero-check pass fails on the first word that reads back nonzero.
- R7: `done` rises when the test ends and holds until the next accepted `start`. It falls in the cycle after that start. `pass_ok` is high only with `done` after all four passes are clean.
- R8: On failure, `fail_bank` and `fail_offset` give the bank and the word index of the first mismatch. They stay stable while `done` holds.
- R9: After reset, `busy`, `done`, `pass_ok`, `wr_en`, `rd_en` and `bank_load` are all low.
- R10: `wr_en` and `rd_en` are never high together. A read is never followed by any access in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a test (pulse) |
| busy | output | 1 | Test in progress |
| done | output | 1 | Test finished; holds until next start |
| pass_ok | output | 1 | All four passes clean (valid with done) |
| fail_bank | output | BANK_W | Bank of first failure |
| fail_offset | output | WORD_W | Word index of first failure |
| bank_load | output | 1 | Bank select strobe with enable |
| bank_idx | output | BANK_W | Bank number to select |
| win_addr | output | WORD_W | Word index in the window |
| wr_en | output | 1 | Window write |
| wr_data | output | DATA_W | Write data |
| rd_en | output | 1 | Window read |
| rd_data | input | DATA_W | Read data, one cycle after rd_en |

## Verification
A start pulse can arrive in the same cycle as a compare, including the final compare that ends the test. The bench raises `start` at several points inside a running test, including the very last busy cycle. It judges the result by checking that the busy length is still the clean-run count, that the result is still pass, and that no restart happens. A bench memory model injects read-side bit flips and lost zero-writes at random and at directed locations. One directed case is a lost clear at a word whose fill value is itself zero; that case must still pass. The expected outcome and failure location come from bench functions.

// File: rtl/mbist_pkg.sv
package mbist_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SEL, ST_ACC, ST_WAIT, ST_DONE
  } st_e;

  typedef enum logic [1:0] {
    PH_FILL, PH_VERIFY, PH_CLEAR, PH_ZERO
  } ph_e;

  function automatic logic is_read(ph_e p);
    return (p == PH_VERIFY) || (p == PH_ZERO);
  endfunction
endpackage

// File: rtl/mbist_seq.sv
module mbist_seq
  import mbist_pkg::*;
#(
  parameter int BANKS  = 4,
  parameter int WORDS  = 16,
  parameter int BANK_W = 2,
  parameter int WORD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mismatch,
  output st_e               state,
  output ph_e               phase,
  output logic [BANK_W-1:0] bank,
  output logic [WORD_W-1:0] word,
  output logic              launch
);
  localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(BANKS - 1);
  localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(WORDS - 1);

  st_e               nx_state;
  ph_e               nx_phase;
  logic [BANK_W-1:0] nx_bank;
  logic [WORD_W-1:0] nx_word;

  assign launch = start && ((state == ST_IDLE) || (state == ST_DONE));

  // next position after the current word is finished
  always_comb begin
    nx_state = ST_ACC;
    nx_phase = phase;
    nx_bank  = bank;
    nx_word  = word + 1'b1;
    if (word == LAST_WORD) begin
      nx_word  = '0;
      nx_state = ST_SEL;
      if (bank == LAST_BANK) begin
        nx_bank = '0;
        if (phase == PH_ZERO) nx_state = ST_DONE;
        else nx_phase = ph_e'(2'(int'(phase) + 1));
      end else begin
        nx_bank = bank + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      phase <= PH_FILL;
      bank  <= '0;
      word  <= '0;
    end else begin
      case (state)
        ST_IDLE, ST_DONE: if (launch) begin
          state <= ST_SEL;
          phase <= PH_FILL;
          bank  <= '0;
          word  <= '0;
        end
        ST_SEL: state <= ST_ACC;
        ST_ACC: begin
          if (is_read(phase)) state <= ST_WAIT;
          else begin
            state <= nx_state;
            phase <= nx_phase;
            bank  <= nx_bank;
            word  <= nx_word;
          end
        end
        ST_WAIT: begin
          if (mismatch) state <= ST_DONE;
          else begin
            state <= nx_state;
            phase <= nx_phase;
            bank  <= nx_bank;
            word  <= nx_word;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state inside {ST_SEL, ST_ACC, ST_WAIT}) && start |=> state != ST_SEL || $past(state) == ST_WAIT || $past(state) == ST_ACC);
endmodule

// File: rtl/mbist_pattern.sv
module mbist_pattern
  import mbist_pkg::*;
#(
  parameter int BANK_W    = 2,
  parameter int WORD_W    = 4,
  parameter int DATA_W    = 16,
  parameter int SEED_STEP = 'h1000
) (
  input  ph_e               phase,
  input  logic [BANK_W-1:0] bank,
  input  logic [WORD_W-1:0] word,
  output logic [DATA_W-1:0] expect_word
);
  logic [31:0] full;

  always_comb begin
    full = 32'(bank) * 32'(SEED_STEP) + 32'(word);
    if ((phase == PH_FILL) || (phase == PH_VERIFY)) expect_word = full[DATA_W-1:0];
    else expect_word = '0;
  end
endmodule

// File: rtl/mbist_cmp.sv
module mbist_cmp #(
  parameter int BANK_W = 2,
  parameter int WORD_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              chk_en,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] expect_word,
  input  logic [BANK_W-1:0] bank,
  input  logic [WORD_W-1:0] word,
  output logic              mismatch,
  output logic              failed,
  output logic [BANK_W-1:0] fail_bank,
  output logic [WORD_W-1:0] fail_offset
);
  assign mismatch = chk_en && (rd_data != expect_word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      failed      <= 1'b0;
      fail_bank   <= '0;
      fail_offset <= '0;
    end else if (launch) begin
      failed      <= 1'b0;
      fail_bank   <= '0;
      fail_offset <= '0;
    end else if (mismatch && !failed) begin
      failed      <= 1'b1;
      fail_bank   <= bank;
      fail_offset <= word;
    end
  end

  // R4
  first_fail_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en && (rd_data != expect_word) && !failed && !launch |=> failed);
endmodule

// File: rtl/banked_mem_bist.sv
module banked_mem_bist
  import mbist_pkg::*;
#(
  parameter int BANKS     = 4,
  parameter int WORDS     = 16,
  parameter int DATA_W    = 16,
  parameter int SEED_STEP = 'h1000,
  localparam int BANK_W   = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int WORD_W   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              pass_ok,
  output logic [BANK_W-1:0] fail_bank,
  output logic [WORD_W-1:0] fail_offset,
  output logic              bank_load,
  output logic [BANK_W-1:0] bank_idx,
  output logic [WORD_W-1:0] win_addr,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_en,
  input  logic [DATA_W-1:0] rd_data
);
  st_e               state;
  ph_e               phase;
  logic [BANK_W-1:0] bank;
  logic [WORD_W-1:0] word;
  logic              launch, mismatch, failed;
  logic [DATA_W-1:0] expect_word;

  mbist_seq #(.BANKS(BANKS), .WORDS(WORDS), .BANK_W(BANK_W), .WORD_W(WORD_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mismatch(mismatch),
    .state(state), .phase(phase), .bank(bank), .word(word), .launch(launch)
  );

  mbist_pattern #(.BANK_W(BANK_W), .WORD_W(WORD_W), .DATA_W(DATA_W), .SEED_STEP(SEED_STEP)) pat_i (
    .phase(phase), .bank(bank), .word(word), .expect_word(expect_word)
  );

  mbist_cmp #(.BANK_W(BANK_W), .WORD_W(WORD_W), .DATA_W(DATA_W)) cmp_i (
    .clk(clk), .rst_n(rst_n), .launch(launch), .chk_en(state == ST_WAIT),
    .rd_data(rd_data), .expect_word(expect_word), .bank(bank), .word(word),
    .mismatch(mismatch), .failed(failed), .fail_bank(fail_bank), .fail_offset(fail_offset)
  );

  assign busy      = (state == ST_SEL) || (state == ST_ACC) || (state == ST_WAIT);
  assign done      = (state == ST_DONE);
  assign pass_ok   = done && !failed;
  assign bank_load = (state == ST_SEL);
  assign bank_idx  = bank;
  assign win_addr  = word;
  assign wr_en     = (state == ST_ACC) && !is_read(phase);
  assign rd_en     = (state == ST_ACC) && is_read(phase);
  assign wr_data   = expect_word;

  // R2
  load_then_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_load |=> (wr_en || rd_en));
  // R10
  no_dual_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_en));
  // R10
  read_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !rd_en && !wr_en);
  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);
  // R8
  fail_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> $stable(fail_bank) && $stable(fail_offset));
  // R7
  pass_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_ok |-> done);
endmodule

// File: tb/banked_mem_bist_tb_top.sv
module banked_mem_bist_tb_top;
  localparam int PERIOD = 10;
  localparam int B = 4;
  localparam int W = 16;
  localparam int TOTAL = 4*B + 6*B*W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done, pass_ok, bank_load, wr_en, rd_en;
  logic [1:0] fail_bank, bank_idx;
  logic [3:0] fail_offset, win_addr;
  logic [15:0] wr_data;
  logic [15:0] rd_data;

  int checks = 0;
  int fails = 0;

  always #(PERIOD/2) clk = ~clk;

  banked_mem_bist dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .pass_ok(pass_ok), .fail_bank(fail_bank), .fail_offset(fail_offset),
    .bank_load(bank_load), .bank_idx(bank_idx), .win_addr(win_addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data)
  );

  // memory model with fault injection: 1 = read bit flip, 2 = lost zero write
  logic [15:0] mem [B][W];
  int   f_kind = 0, f_bank = 0, f_word = 0;
  logic [15:0] f_mask = 16'h0001;
  int   cur = 0, nxt_load = 0, wcount = 0, lcount = 0, mon_err = 0;
  bit   loaded = 0;

  function automatic logic [15:0] pat(int b, int w);
    return 16'(b*4096 + w);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < B; b++) for (int w = 0; w < W; w++) mem[b][w] <= 16'hDEAD;
      rd_data <= '0;
    end else begin
      if (start && !busy) begin
        wcount = 0; lcount = 0; nxt_load = 0; mon_err = 0; loaded = 0;
      end
      if ((wr_en || rd_en) && !loaded) mon_err++;
      if (wr_en) begin
        int exp_b, exp_w;
        exp_b = (wcount % (B*W)) / W;
        exp_w = wcount % W;
        if (cur != exp_b || int'(win_addr) != exp_w) mon_err++;
        if (wcount < B*W) begin
          if (wr_data != pat(exp_b, exp_w)) mon_err++;
        end else if (wr_data != 16'h0) mon_err++;
        wcount++;
        if (!(f_kind == 2 && cur == f_bank && int'(win_addr) == f_word && wr_data == 16'h0))
          mem[cur][win_addr] <= wr_data;
      end
      if (rd_en)
        rd_data <= mem[cur][win_addr] ^
                   ((f_kind == 1 && cur == f_bank && int'(win_addr) == f_word) ? f_mask : 16'h0);
      if (bank_load) begin
        if (int'(bank_idx) != nxt_load) mon_err++;
        nxt_load = (int'(bank_idx) == B-1) ? 0 : int'(bank_idx) + 1;
        cur = int'(bank_idx);
        loaded = 1;
        lcount++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_run(input int kind, input int fb, input int fw, input logic [15:0] mask,
                        input int poke, output int cyc);
    int guard = 0;
    f_kind = kind; f_bank = fb; f_word = fw; f_mask = mask;
    cyc = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && guard < 4000) begin
      if (busy) cyc++;
      start = (cyc == poke);
      guard++;
      @(negedge clk);
    end
    start = 1'b0;
    if (guard >= 4000) check(0, "R1 watchdog", guard, 0);
  endtask

  task automatic run_judge(input int kind, input int fb, input int fw, input logic [15:0] mask,
                           input int poke);
    int cyc;
    bit exp_pass;
    do_run(kind, fb, fw, mask, poke, cyc);
    exp_pass = (kind == 0) || (kind == 2 && pat(fb, fw) == 16'h0);
    check(done == 1'b1, "R7 done", int'(done), 1);
    check(mon_err == 0, "R2/R3/R5 order and data (R2 R3 R5)", mon_err, 0);
    if (exp_pass) begin
      check(pass_ok == 1'b1, "R7 pass", int'(pass_ok), 1);
      check(cyc == TOTAL, "R1 run length", cyc, TOTAL);
      check(lcount == 4*B, "R2 load count", lcount, 4*B);
      check(wcount == 2*B*W, "R5 write count", wcount, 2*B*W);
    end else begin
      check(pass_ok == 1'b0, kind == 1 ? "R4 mismatch" : "R6 nonzero", int'(pass_ok), 0);
      check(int'(fail_bank) == fb, "R8 bank", int'(fail_bank), fb);
      check(int'(fail_offset) == fw, "R8 offset", int'(fail_offset), fw);
    end
    repeat (3) @(negedge clk);
    check(done == 1'b1 && pass_ok == exp_pass, "R7 hold", int'(pass_ok), int'(exp_pass));
    if (!exp_pass) check(int'(fail_bank) == fb && int'(fail_offset) == fw, "R8 stable",
                         int'(fail_offset), fw);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    // R9 reset state
    check(!busy && !done && !pass_ok && !wr_en && !rd_en && !bank_load, "R9 reset",
          {busy, done, pass_ok, wr_en, rd_en, bank_load}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_judge(0, 0, 0, 16'h0, -1);
    // R7 restart: done falls one cycle after start
    start = 1'b1; @(negedge clk); start = 1'b0;
    check(done == 1'b0 && busy == 1'b1, "R7 restart", int'(done), 0);
    while (!done) @(negedge clk);
    // R1 start mid-run and on the final compare cycle are ignored
    run_judge(0, 0, 0, 16'h0, 37);
    run_judge(0, 0, 0, 16'h0, TOTAL);
    // directed faults
    run_judge(1, 0, 0, 16'h8000, -1);      // R4 first word
    run_judge(1, B-1, W-1, 16'h0001, -1);  // R4 last word
    run_judge(2, 1, 3, 16'h0, -1);         // R6 lost clear
    run_judge(2, 0, 0, 16'h0, -1);         // R6 lost clear at zero pattern: passes
    // R10 random mix
    for (int i = 0; i < 8; i++) begin
      int k;
      logic [15:0] m;
      k = int'($urandom_range(2, 0));
      m = 16'($urandom_range(16'hFFFF, 1));
      run_judge(k, int'($urandom_range(B-1, 0)), int'($urandom_range(W-1, 0)), m,
                int'($urandom_range(TOTAL + 5, 1)));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL R1 global watchdog: actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule